// File: doc/BRIEF.md
# Host-to-Coprocessor Byte Mailbox

This block carries single bytes between a 16-bit host processor and an 8-bit sound coprocessor. The host writes a command byte on the upper half of its data bus (the lane that carries bits 15..8). The block stores the byte and gives a one-clock "written" pulse. An interrupt controller outside this block can turn that pulse into a coprocessor interrupt. The coprocessor fetches the stored byte over its own bidirectional 8-bit bus by asserting its read strobe. It can send back a reply byte with its write strobe, and the host reads the reply on the same upper lane.

The host write strobe and the coprocessor write strobe each pass through a configurable number of synchroniser flops. A capture then happens once, on the first clock at which the synchronised request is seen active. The bus drivers respond combinationally to the raw read strobes. A synchronous clear input returns the stored command byte to zero. A host capture in the same cycle as a clear takes precedence over the clear.

Top module: `snd_mailbox`

## Requirements
- R1: After a synchronous reset with `rst_n` low, the stored command byte and the reply byte are both 0x00, `written` is low, and `cop_drive` is low.
- R2: A host write is recognised when `host_sel`=1, `host_as_n`=0, `host_uds_n`=0 and `host_rw`=0. The block captures `host_wd` into the command byte at the (SYNC_STAGES+1)-th rising clock edge after the strobes are first seen active, provided the data is still held at that edge.
- R3: Each recognised host write makes `written` high for exactly one clock, starting at the same edge as the capture. This holds no matter how long the strobes stay asserted.
- R4: A host access with `host_uds_n`=1, with `host_rw`=1, or with `host_sel`=0 leaves the command byte unchanged and produces no `written` pulse.
- R5: While `cop_rd_n`=0, the block drives `cop_data` with the command byte and `cop_drive` is 1, with no clock delay. While `cop_rd_n`=1, `cop_drive` is 0 and `cop_data` is released to high impedance.
- R6: `clr` high at a rising edge where no host capture occurs sets the command byte to 0x00 after that edge.
- R7: When a host capture and `clr` fall on the same edge, the command byte takes the host data.
- R8: With `cop_wr_n`=0 and `cop_rd_n`=1, the block latches `cop_data` into the reply byte at the (SYNC_STAGES+1)-th edge.
- R9: A host read (`host_sel`=1, `host_as_n`=0, `host_uds_n`=0, `host_rw`=1) sets `host_oe`=1 with no clock delay and presents the reply byte on `host_rd`.
- R10: A coprocessor write strobe given while `cop_rd_n`=0 is ignored, and the reply byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host address decode hit for the mailbox port |
| host_as_n | input | 1 | Host address strobe, active low |
| host_uds_n | input | 1 | Host upper byte strobe, active low |
| host_rw | input | 1 | Host direction: 1 read, 0 write |
| host_wd | input | 8 | Host data bits 15..8 for writes |
| host_rd | output | 8 | Reply byte returned on host bits 15..8 |
| host_oe | output | 1 | Host read enable for the upper lane |
| written | output | 1 | One-clock pulse per host write |
| clr | input | 1 | Synchronous clear of the command byte |
| cop_rd_n | input | 1 | Coprocessor read strobe, active low |
| cop_wr_n | input | 1 | Coprocessor write strobe, active low |
| cop_data | inout | 8 | Coprocessor bidirectional data bus |
| cop_drive | output | 1 | High while the block drives `cop_data` |

## Verification
Both capture paths are registered. The command byte, the `written` pulse and the reply byte all change at the (SYNC_STAGES+1)-th rising edge after the strobe is applied. The bench applies stimulus on a falling edge and counts exactly that many rising edges before it samples on the next falling edge. One edge earlier, it also checks that nothing has changed yet. `cop_data`, `cop_drive`, `host_rd` and `host_oe` respond with no clock delay, so the bench samples them a short delay after it changes the strobes. The clear-versus-write tie is set up by raising `clr` in the cycle just before the capture edge.

// File: rtl/snd_mailbox_pkg.sv
// Package: shared defaults for the mailbox block.
// Assumes: all consumers import these as parameter defaults only.
package snd_mailbox_pkg;
    localparam int unsigned MBX_BYTE_W      = 8;
    localparam int unsigned MBX_SYNC_STAGES = 2;
endpackage

// File: rtl/mbx_sync.sv
// mbx_sync: delays an active-high level through STAGES flops (0 = wire).
// Assumes: the input is a level held for more than STAGES+1 clocks.
module mbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic lvl_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign lvl_out = lvl_in;
        end else begin : g_chain
            logic [STAGES-1:0] stage_q;
            for (genvar g = 0; g < STAGES; g++) begin : g_stage
                if (g == 0) begin : g_first
                    // First flop samples the raw request level.
                    always_ff @(posedge clk) begin
                        if (!rst_n) stage_q[g] <= 1'b0;
                        else        stage_q[g] <= lvl_in;
                    end
                end else begin : g_next
                    // Later flops shift the level one stage on.
                    always_ff @(posedge clk) begin
                        if (!rst_n) stage_q[g] <= 1'b0;
                        else        stage_q[g] <= stage_q[g-1];
                    end
                end
            end
            assign lvl_out = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mbx_edge.sv
// mbx_edge: flags the first cycle a synchronised level is high.
// Assumes: the level is already in the clk domain.
module mbx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    // Remember the level from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    // R3: a held request yields only one rise.
    a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mbx_latch.sv
// mbx_latch: byte register with load, synchronous clear, load over clear.
// Assumes: load and clr are single-clock qualified controls.
module mbx_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold, load or clear the stored byte; load has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
        else if (clr)  q <= '0;
    end

    // R7: a load always lands, even with clr present.
    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d));
    // R6: a clear without a load leaves zero.
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> q == '0);
    // R4: no control means no change.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load) |=> $stable(q));
endmodule

// File: rtl/snd_mailbox.sv
// snd_mailbox: host-to-coprocessor command byte plus a reply byte.
// Assumes: host and coprocessor strobes may be asynchronous to clk and
// are held longer than SYNC_STAGES+1 clocks with data stable meanwhile.
module snd_mailbox
    import snd_mailbox_pkg::*;
#(
    parameter int unsigned BYTE_W      = MBX_BYTE_W,
    parameter int unsigned SYNC_STAGES = MBX_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_as_n,
    input  logic              host_uds_n,
    input  logic              host_rw,
    input  logic [BYTE_W-1:0] host_wd,
    output logic [BYTE_W-1:0] host_rd,
    output logic              host_oe,
    output logic              written,
    input  logic              clr,
    input  logic              cop_rd_n,
    input  logic              cop_wr_n,
    inout  wire  [BYTE_W-1:0] cop_data,
    output logic              cop_drive
);
    logic              host_hit;
    logic              hw_req, hw_lvl, hw_rise;
    logic              cw_req, cw_lvl, cw_rise;
    logic [BYTE_W-1:0] cmd_q, reply_q;

    // Raw request decode for both sides.
    always_comb begin
        host_hit = host_sel & ~host_as_n & ~host_uds_n;
        hw_req   = host_hit & ~host_rw;
        cw_req   = ~cop_wr_n & cop_rd_n;
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) u_hw_sync (
        .clk(clk), .rst_n(rst_n), .lvl_in(hw_req), .lvl_out(hw_lvl));
    mbx_edge u_hw_edge (
        .clk(clk), .rst_n(rst_n), .lvl(hw_lvl), .rise(hw_rise));
    mbx_sync #(.STAGES(SYNC_STAGES)) u_cw_sync (
        .clk(clk), .rst_n(rst_n), .lvl_in(cw_req), .lvl_out(cw_lvl));
    mbx_edge u_cw_edge (
        .clk(clk), .rst_n(rst_n), .lvl(cw_lvl), .rise(cw_rise));

    mbx_latch #(.W(BYTE_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .load(hw_rise), .clr(clr),
        .d(host_wd), .q(cmd_q));
    mbx_latch #(.W(BYTE_W)) u_reply (
        .clk(clk), .rst_n(rst_n), .load(cw_rise), .clr(1'b0),
        .d(cop_data), .q(reply_q));

    // Notify pulse aligned with the command capture.
    always_ff @(posedge clk) begin
        if (!rst_n) written <= 1'b0;
        else        written <= hw_rise;
    end

    // Bus drive: coprocessor read and host read paths.
    assign cop_drive = ~cop_rd_n;
    assign cop_data  = cop_drive ? cmd_q : {BYTE_W{1'bz}};
    assign host_oe   = host_hit & host_rw;
    assign host_rd   = reply_q;

    // R3: the notify pulse never lasts two clocks.
    a_r3_written_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        written |=> !written);
    // R2: the pulse comes with the host byte present at the capture edge.
    a_r2_captured: assert property (@(posedge clk) disable iff (!rst_n)
        written |-> cmd_q == $past(host_wd));
endmodule

// File: tb/snd_mailbox_tb_top.sv
module snd_mailbox_tb_top;
    localparam int SYNC = 2;
    localparam int NV   = 8;
    // Vector fields: {sel, uds_n, rw, data[7:0]}
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 8'hA5}, {1'b1, 1'b1, 1'b0, 8'h11},
        {1'b1, 1'b0, 1'b0, 8'h3C}, {1'b1, 1'b0, 1'b1, 8'h22},
        {1'b0, 1'b0, 1'b0, 8'h33}, {1'b1, 1'b0, 1'b0, 8'hFF},
        {1'b1, 1'b0, 1'b0, 8'h00}, {1'b1, 1'b0, 1'b0, 8'h81}};

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_sel = 0, host_as_n = 1, host_uds_n = 1, host_rw = 1;
    logic [7:0] host_wd = 0, host_rd;
    logic host_oe, written, clr = 0, cop_rd_n = 1, cop_wr_n = 1, cop_drive;
    logic tb_drv = 0;
    logic [7:0] tb_val = 0;
    wire  [7:0] cop_data;
    int checks = 0, fails = 0;
    logic [7:0] model = 0;
    bit done = 0;

    assign cop_data = tb_drv ? tb_val : 8'hzz;
    always #4 clk = ~clk;

    snd_mailbox #(.BYTE_W(8), .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_as_n(host_as_n),
        .host_uds_n(host_uds_n), .host_rw(host_rw), .host_wd(host_wd),
        .host_rd(host_rd), .host_oe(host_oe), .written(written), .clr(clr),
        .cop_rd_n(cop_rd_n), .cop_wr_n(cop_wr_n), .cop_data(cop_data),
        .cop_drive(cop_drive));

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        host_sel = 0; host_as_n = 1; host_uds_n = 1; host_rw = 1;
    endtask

    task automatic cop_read(string tag, logic [7:0] exp);
        @(negedge clk); cop_rd_n = 0; #1;
        check(tag, {7'd0, cop_drive, cop_data}, {8'h01, exp});
        cop_rd_n = 1; #1;
        check(tag, {15'd0, cop_drive}, 16'd0);
    endtask

    task automatic host_read(string tag, logic [7:0] exp);
        @(negedge clk);
        host_sel = 1; host_as_n = 0; host_uds_n = 0; host_rw = 1; #1;
        check(tag, {7'd0, host_oe, host_rd}, {8'h01, exp});
        idle_bus();
    endtask

    // Host access; checks pulse timing; optional clr in cycle before capture.
    task automatic host_access(logic sel, logic uds_n, logic rw, logic [7:0] d,
                               logic clr_tie);
        logic hit;
        hit = sel & ~uds_n & ~rw;
        @(negedge clk);
        host_sel = sel; host_as_n = 0; host_uds_n = uds_n; host_rw = rw; host_wd = d;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        check("R3 no early pulse", {15'd0, written}, 16'd0);
        clr = clr_tie;
        @(posedge clk);
        @(negedge clk);
        clr = 0;
        check(hit ? "R3 pulse at capture" : "R4 no pulse", {15'd0, written}, {15'd0, hit});
        if (hit) model = d;
        @(posedge clk); @(negedge clk);
        check("R3 pulse one clock", {15'd0, written}, 16'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 held strobe no repeat", {15'd0, written}, 16'd0);
        idle_bus();
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        check("R1 written", {15'd0, written}, 16'd0);
        check("R1 cop_drive", {15'd0, cop_drive}, 16'd0);
        cop_read("R1 command zero", 8'h00);
        host_read("R1 reply zero", 8'h00);

        // R2 R4 R5 vector walk
        for (int i = 0; i < NV; i++) begin
            host_access(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0], 1'b0);
            cop_read("R2 R4 R5 stored byte", model);
        end

        // R6 clear
        host_access(1, 0, 0, 8'h5A, 0);
        @(negedge clk); clr = 1;
        @(posedge clk); @(negedge clk); clr = 0;
        cop_read("R6 cleared", 8'h00);

        // R7 capture beats clear on same edge
        host_access(1, 0, 0, 8'h6B, 1);
        cop_read("R7 write wins", 8'h6B);

        // R8 reply write, R9 host read
        @(negedge clk); tb_drv = 1; tb_val = 8'hC3; cop_wr_n = 0;
        repeat (SYNC) @(posedge clk);
        host_read("R8 not yet latched", 8'h00);
        @(posedge clk);
        host_read("R8 R9 reply latched", 8'hC3);
        @(negedge clk); cop_wr_n = 1; tb_drv = 0;
        repeat (4) @(posedge clk);
        host_read("R9 reply held", 8'hC3);

        // R10 write strobe during read is ignored
        @(negedge clk); cop_rd_n = 0; cop_wr_n = 0;
        repeat (SYNC + 4) @(posedge clk);
        @(negedge clk); cop_rd_n = 1; cop_wr_n = 1;
        repeat (SYNC + 2) @(posedge clk);
        host_read("R10 reply unchanged", 8'hC3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule